// File: doc/BRIEF.md
# NAND Flash Command Sequencer

This block is the device-side command decoder of a byte-wide NAND flash array model. A host drives an 8-bit bus. Each write cycle is one clock with `wrEn` high. `cmdLatch` marks a command byte, `addrLatch` marks an address byte, and a write with neither strobe is a data byte. A write with both strobes high is ignored. The block accepts the two-step page program sequence (80h, four address cycles, data, then 10h) and the two-step block erase sequence (60h, three address cycles, then D0h). It holds a page register of 528 bytes, 512 main bytes followed by 16 spare bytes, and drives `readyBusy` low while an operation runs. Status reads come back on `busOut`.

Programming copies the page register into a small behavioural cell array, one byte per clock, during the busy window. A cell can only move from 1 to 0. One parameterised defective cell has bits stuck at 1, which lets the verify step report a failure. Each page keeps two counters of partial programs: one for the main area and one for the spare area. An erase clears the counters of every page in the erased block. The busy durations are fixed cycle counts set by parameters.

Address layout: the first program address cycle is the start column. The following row bytes give the row bits [7:0], [15:8] and [17:16], in that order. The erase row bytes use the same order. Row bits [4:0] select the page within a block, and row bits [17:5] select the block. The model decodes only the low `PG_BITS` of the page field and the low `BLK_BITS` of the block field.

Top module: `nand_cmd_seq`

## Requirements
- R1: After reset `readyBusy` is 1 and `busOut` is 00h. A 70h command followed by a read then returns 40h.
- R2: The sequence 80h, four address cycles, data and 10h starts a program. `readyBusy` is 0 from the clock after 10h for exactly `PROG_CYCLES` clocks, and a successful program leaves status bit 0 at 0.
- R3: A 10h command with no 80h before it, or sent after fewer than four address cycles, is ignored and `readyBusy` stays 1.
- R4: The sequence 60h, three address cycles and D0h starts an erase that is busy for exactly `ERASE_CYCLES` clocks. A D0h command without a complete erase setup is ignored.
- R5: An erase selects the block from row bits [17:5] only, and ignores row bits [4:0]. It clears the partial-program counts of every page in that block, so the main area of a page can be programmed again.
- R6: While busy, only 70h and FFh take effect. Any other command is dropped: the busy length does not change, status mode is kept, and a dropped 80h does not arm a later 10h.
- R7: The status byte has bit 6 = ready and bit 0 = fail, with all other bits 0. `busOut` takes a new value on the clock that samples `rdEn`.
- R8: After 70h, every read returns the status byte until an accepted 80h, 60h, confirm or FFh arrives. An ignored command does not end status mode. Outside status mode, reads return 00h.
- R9: An area of a page counts as programmed only if a byte loaded into it differs from FFh. A second main-area program of a page sets the fail bit. A third spare-area program of a page sets the fail bit. A rejected attempt is still busy for `PROG_CYCLES`.
- R10: Verify reports a failure only when a bit loaded as 0 still reads 1 after programming. Loading FFh over the stuck cell (`STUCK_PAGE`, `STUCK_COL`, `STUCK_MASK`) does not fail, but loading 00h there does.
- R11: FFh ends any operation and returns `readyBusy` to 1 on the next clock. It also clears the fail bit, leaves status mode and discards a pending setup.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busIn | input | 8 | Command, address or data byte |
| cmdLatch | input | 1 | Marks the write cycle as a command |
| addrLatch | input | 1 | Marks the write cycle as an address |
| wrEn | input | 1 | Write cycle strobe, one byte per clock |
| rdEn | input | 1 | Read cycle strobe |
| busOut | output | 8 | Read data: the status byte in status mode, otherwise 00h |
| readyBusy | output | 1 | 1 = ready, 0 = operation in progress |

## Verification
The hardest state to reach from the ports is a spare-area-only partial program. Every loaded byte below column 512 must be FFh, or it would use up the main-area allowance. The stimulus therefore loads a full 528-byte page from column 0 with FFh in the main part. It repeats that page program three times to push the spare counter past its limit. The verify failure needs the one defective cell: it is reached by programming 00h at the stuck column of the stuck page right after an erase, so that the partial-program limit cannot hide the result. Commands dropped while busy are shown by issuing 80h and 10h mid-operation and then checking the busy length, the status mode, and that no program is armed afterwards.

// File: rtl/nand_seq_pkg.sv
package nand_seq_pkg;
  // command codes
  localparam logic [7:0] CMD_LOAD   = 8'h80;
  localparam logic [7:0] CMD_PROG   = 8'h10;
  localparam logic [7:0] CMD_ESETUP = 8'h60;
  localparam logic [7:0] CMD_ECONF  = 8'hD0;
  localparam logic [7:0] CMD_STAT   = 8'h70;
  localparam logic [7:0] CMD_RST    = 8'hFF;

  localparam int ROW_W     = 18;  // row bits A9..A26
  localparam int ROW_BYTES = 3;
  localparam int BLK_SHIFT = 5;   // page-in-block field width of the row
  localparam int ST_READY  = 6;
  localparam int ST_FAIL   = 0;

  typedef enum logic [2:0] {
    SEQ_IDLE, SEQ_PADDR, SEQ_LOAD, SEQ_EADDR, SEQ_EARM, SEQ_BUSY
  } seqState_t;

  typedef struct packed {
    logic clearReg;
    logic setCol;
    logic wrByte;
    logic startProg;
    logic startErase;
    logic abort;
  } dpStrb_t;
endpackage

// File: rtl/nand_seq_ctrl.sv
module nand_seq_ctrl
  import nand_seq_pkg::*;
#(
  parameter int PROG_CYCLES  = 600,
  parameter int ERASE_CYCLES = 1200
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [7:0]       busIn,
  input  logic             cmdLatch,
  input  logic             addrLatch,
  input  logic             wrEn,
  input  logic             rdEn,
  input  logic             failPulse,
  output dpStrb_t          strb,
  output logic [ROW_W-1:0] row,
  output logic [7:0]       busOut,
  output logic             readyBusy
);
  localparam int LONGEST  = (PROG_CYCLES > ERASE_CYCLES) ? PROG_CYCLES : ERASE_CYCLES;
  localparam int CNT_W    = $clog2(LONGEST + 1);
  localparam int ROWREG_W = ROW_BYTES * 8;

  seqState_t            state;
  logic [1:0]           addrCnt;
  logic [ROWREG_W-1:0]  rowReg;
  logic [CNT_W-1:0]     busyCnt;
  logic                 statMode;
  logic                 failBit;
  logic                 cmdWr, addrWr, dataWr, busy;
  logic [7:0]           statusByte;
  logic                 unusedRowTop;

  assign cmdWr  = wrEn & cmdLatch & ~addrLatch;
  assign addrWr = wrEn & addrLatch & ~cmdLatch;
  assign dataWr = wrEn & ~cmdLatch & ~addrLatch;
  assign busy   = (state == SEQ_BUSY);
  assign readyBusy = ~busy;
  assign row = rowReg[ROW_W-1:0];
  assign unusedRowTop = ^rowReg[ROWREG_W-1:ROW_W];

  always_comb begin
    statusByte = 8'h00;
    statusByte[ST_READY] = ~busy;
    statusByte[ST_FAIL]  = failBit;
  end

  // strobes toward the datapath
  always_comb begin
    strb = '0;
    if (cmdWr) begin
      if (busIn == CMD_RST) strb.abort = 1'b1;
      else if (!busy) begin
        case (busIn)
          CMD_LOAD:  strb.clearReg   = 1'b1;
          CMD_PROG:  strb.startProg  = (state == SEQ_LOAD);
          CMD_ECONF: strb.startErase = (state == SEQ_EARM);
          default:   ;
        endcase
      end
    end
    strb.setCol = addrWr && (state == SEQ_PADDR) && (addrCnt == 2'd0);
    strb.wrByte = dataWr && (state == SEQ_LOAD);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= SEQ_IDLE;
      addrCnt  <= '0;
      rowReg   <= '0;
      busyCnt  <= '0;
      statMode <= 1'b0;
      failBit  <= 1'b0;
      busOut   <= 8'h00;
    end else begin
      if (failPulse) failBit <= 1'b1;
      if (rdEn) busOut <= statMode ? statusByte : 8'h00;

      if (busy) begin
        if (busyCnt == '0) state <= SEQ_IDLE;
        else busyCnt <= busyCnt - 1'b1;
      end

      if (cmdWr) begin
        case (busIn)
          CMD_RST: begin
            state    <= SEQ_IDLE;
            addrCnt  <= '0;
            statMode <= 1'b0;
            failBit  <= 1'b0;
          end
          CMD_STAT: statMode <= 1'b1;
          CMD_LOAD: if (!busy) begin
            state    <= SEQ_PADDR;
            addrCnt  <= '0;
            statMode <= 1'b0;
          end
          CMD_ESETUP: if (!busy) begin
            state    <= SEQ_EADDR;
            addrCnt  <= '0;
            statMode <= 1'b0;
          end
          CMD_PROG: if (!busy && state == SEQ_LOAD) begin
            state    <= SEQ_BUSY;
            busyCnt  <= CNT_W'(PROG_CYCLES - 1);
            failBit  <= 1'b0;
            statMode <= 1'b0;
          end
          CMD_ECONF: if (!busy && state == SEQ_EARM) begin
            state    <= SEQ_BUSY;
            busyCnt  <= CNT_W'(ERASE_CYCLES - 1);
            failBit  <= 1'b0;
            statMode <= 1'b0;
          end
          default: ;
        endcase
      end else if (addrWr) begin
        if (state == SEQ_PADDR) begin
          if (addrCnt != 2'd0) rowReg[8*(addrCnt - 2'd1) +: 8] <= busIn;
          addrCnt <= addrCnt + 2'd1;
          if (addrCnt == 2'd3) state <= SEQ_LOAD;
        end else if (state == SEQ_EADDR) begin
          rowReg[8*addrCnt +: 8] <= busIn;
          addrCnt <= addrCnt + 2'd1;
          if (addrCnt == 2'd2) state <= SEQ_EARM;
        end
      end
    end
  end
endmodule

// File: rtl/nand_seq_dp.sv
module nand_seq_dp
  import nand_seq_pkg::*;
#(
  parameter int         PAGE_BYTES  = 528,
  parameter int         MAIN_BYTES  = 512,
  parameter int         PG_BITS     = 1,
  parameter int         BLK_BITS    = 1,
  parameter int         MAIN_QUOTA  = 1,
  parameter int         SPARE_QUOTA = 2,
  parameter int         STUCK_PAGE  = 1,
  parameter int         STUCK_COL   = 5,
  parameter logic [7:0] STUCK_MASK  = 8'h04
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrb_t          strb,
  input  logic [7:0]       din,
  input  logic [ROW_W-1:0] row,
  output logic             failPulse
);
  localparam int PIDX_W     = PG_BITS + BLK_BITS;
  localparam int NUM_PAGES  = 1 << PIDX_W;
  localparam int BLK_CELLS  = (1 << PG_BITS) * PAGE_BYTES;
  localparam int CELLS      = NUM_PAGES * PAGE_BYTES;
  localparam int PTR_W      = $clog2(PAGE_BYTES + 1);
  localparam int ADDR_W     = $clog2(CELLS);
  localparam int IDX_W      = $clog2(BLK_CELLS);
  localparam int QMAX       = (MAIN_QUOTA > SPARE_QUOTA) ? MAIN_QUOTA : SPARE_QUOTA;
  localparam int QW         = $clog2(QMAX + 1);
  localparam int STUCK_ADDR = STUCK_PAGE * PAGE_BYTES + STUCK_COL;

  typedef enum logic [1:0] {ENG_IDLE, ENG_PROG, ENG_ERASE} engMode_t;

  // page register
  logic [7:0]       pageReg [PAGE_BYTES];
  logic [PTR_W-1:0] ptr;
  logic             dirtyMain, dirtySpare;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      ptr        <= '0;
      dirtyMain  <= 1'b0;
      dirtySpare <= 1'b0;
    end else if (strb.clearReg) begin
      for (int i = 0; i < PAGE_BYTES; i++) pageReg[i] <= 8'hFF;
      ptr        <= '0;
      dirtyMain  <= 1'b0;
      dirtySpare <= 1'b0;
    end else if (strb.setCol) begin
      ptr <= PTR_W'(din);
    end else if (strb.wrByte && ptr < PTR_W'(PAGE_BYTES)) begin
      pageReg[ptr] <= din;
      ptr <= ptr + 1'b1;
      if (din != 8'hFF) begin
        if (ptr < PTR_W'(MAIN_BYTES)) dirtyMain <= 1'b1;
        else dirtySpare <= 1'b1;
      end
    end
  end

  // address decode
  logic [BLK_BITS-1:0] blkSel;
  logic [PIDX_W-1:0]   pageSel;
  logic                unusedRow;
  assign blkSel    = row[BLK_SHIFT +: BLK_BITS];
  assign pageSel   = {blkSel, row[PG_BITS-1:0]};
  assign unusedRow = ^row;

  // per-page partial program counters
  logic [NUM_PAGES*QW-1:0] mainCntFlat, spareCntFlat;
  logic [QW-1:0]           curMain, curSpare;
  logic                    quotaBad, progOk;

  assign curMain  = mainCntFlat[pageSel*QW +: QW];
  assign curSpare = spareCntFlat[pageSel*QW +: QW];
  assign quotaBad = (dirtyMain  && curMain  >= QW'(MAIN_QUOTA)) ||
                    (dirtySpare && curSpare >= QW'(SPARE_QUOTA));
  assign progOk   = strb.startProg && !quotaBad;

  for (genvar p = 0; p < NUM_PAGES; p++) begin : g_page
    localparam logic [PIDX_W-1:0] PID = PIDX_W'(p);
    logic [QW-1:0] mCnt, sCnt;
    logic          hit, blkHit;
    assign hit    = (pageSel == PID);
    assign blkHit = (blkSel == PID[PIDX_W-1 -: BLK_BITS]);
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        mCnt <= '0;
        sCnt <= '0;
      end else if (strb.startErase && blkHit) begin
        mCnt <= '0;
        sCnt <= '0;
      end else if (progOk && hit) begin
        if (dirtyMain)  mCnt <= mCnt + 1'b1;
        if (dirtySpare) sCnt <= sCnt + 1'b1;
      end
    end
    assign mainCntFlat[p*QW +: QW]  = mCnt;
    assign spareCntFlat[p*QW +: QW] = sCnt;
  end

  // byte-serial commit engine over the cell array
  logic [7:0]        cells [CELLS];
  engMode_t          mode;
  logic [IDX_W-1:0]  engIdx;
  logic [ADDR_W-1:0] engBase, cellAddr;
  logic [7:0]        srcByte, stuckBits, newVal;

  assign cellAddr  = engBase + ADDR_W'(engIdx);
  assign srcByte   = pageReg[PTR_W'(engIdx)];
  assign stuckBits = (cellAddr == ADDR_W'(STUCK_ADDR)) ? STUCK_MASK : 8'h00;
  assign newVal    = (cells[cellAddr] & srcByte) | stuckBits;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < CELLS; i++) cells[i] <= 8'hFF;
      mode      <= ENG_IDLE;
      engIdx    <= '0;
      engBase   <= '0;
      failPulse <= 1'b0;
    end else begin
      failPulse <= 1'b0;
      if (strb.abort) begin
        mode <= ENG_IDLE;
      end else if (strb.startProg) begin
        if (quotaBad) failPulse <= 1'b1;
        else begin
          mode    <= ENG_PROG;
          engIdx  <= '0;
          engBase <= ADDR_W'(pageSel) * ADDR_W'(PAGE_BYTES);
        end
      end else if (strb.startErase) begin
        mode    <= ENG_ERASE;
        engIdx  <= '0;
        engBase <= ADDR_W'(blkSel) * ADDR_W'(BLK_CELLS);
      end else begin
        case (mode)
          ENG_PROG: begin
            cells[cellAddr] <= newVal;
            if ((~srcByte & newVal) != 8'h00) failPulse <= 1'b1;
            if (engIdx == IDX_W'(PAGE_BYTES - 1)) mode <= ENG_IDLE;
            else engIdx <= engIdx + 1'b1;
          end
          ENG_ERASE: begin
            cells[cellAddr] <= 8'hFF;
            if (engIdx == IDX_W'(BLK_CELLS - 1)) mode <= ENG_IDLE;
            else engIdx <= engIdx + 1'b1;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/nand_cmd_seq.sv
module nand_cmd_seq
  import nand_seq_pkg::*;
#(
  parameter int         PAGE_BYTES   = 528,
  parameter int         MAIN_BYTES   = 512,
  parameter int         PG_BITS      = 1,
  parameter int         BLK_BITS     = 1,
  parameter int         MAIN_QUOTA   = 1,
  parameter int         SPARE_QUOTA  = 2,
  parameter int         PROG_CYCLES  = 600,
  parameter int         ERASE_CYCLES = 1200,
  parameter int         STUCK_PAGE   = 1,
  parameter int         STUCK_COL    = 5,
  parameter logic [7:0] STUCK_MASK   = 8'h04
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [7:0] busIn,
  input  logic       cmdLatch,
  input  logic       addrLatch,
  input  logic       wrEn,
  input  logic       rdEn,
  output logic [7:0] busOut,
  output logic       readyBusy
);
  dpStrb_t          strb;
  logic [ROW_W-1:0] row;
  logic             failPulse;

  nand_seq_ctrl #(
    .PROG_CYCLES (PROG_CYCLES),
    .ERASE_CYCLES(ERASE_CYCLES)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .busIn    (busIn),
    .cmdLatch (cmdLatch),
    .addrLatch(addrLatch),
    .wrEn     (wrEn),
    .rdEn     (rdEn),
    .failPulse(failPulse),
    .strb     (strb),
    .row      (row),
    .busOut   (busOut),
    .readyBusy(readyBusy)
  );

  nand_seq_dp #(
    .PAGE_BYTES (PAGE_BYTES),
    .MAIN_BYTES (MAIN_BYTES),
    .PG_BITS    (PG_BITS),
    .BLK_BITS   (BLK_BITS),
    .MAIN_QUOTA (MAIN_QUOTA),
    .SPARE_QUOTA(SPARE_QUOTA),
    .STUCK_PAGE (STUCK_PAGE),
    .STUCK_COL  (STUCK_COL),
    .STUCK_MASK (STUCK_MASK)
  ) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .strb     (strb),
    .din      (busIn),
    .row      (row),
    .failPulse(failPulse)
  );
endmodule

// File: rtl/nand_cmd_seq_chk.sv
module nand_cmd_seq_chk
  import nand_seq_pkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic [7:0] busIn,
  input logic       cmdLatch,
  input logic       addrLatch,
  input logic       wrEn,
  input logic [7:0] busOut,
  input logic       readyBusy,
  input dpStrb_t    strb
);
  // R11
  rst_cmd_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && cmdLatch && !addrLatch && busIn == CMD_RST) |=> readyBusy);

  // R2
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.startProg || strb.startErase) |=> !readyBusy);

  // R3
  busy_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(readyBusy) |-> $past(strb.startProg || strb.startErase));

  // R6
  busy_no_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    !readyBusy |-> !(strb.startProg || strb.startErase || strb.clearReg));

  // R7
  stat_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busOut & 8'hBE) == 8'h00);
endmodule

bind nand_cmd_seq nand_cmd_seq_chk chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .busIn    (busIn),
  .cmdLatch (cmdLatch),
  .addrLatch(addrLatch),
  .wrEn     (wrEn),
  .busOut   (busOut),
  .readyBusy(readyBusy),
  .strb     (strb)
);

// File: tb/nand_cmd_seq_tb_top.sv
module nand_cmd_seq_tb_top;
  localparam int PROG_CYCLES  = 600;
  localparam int ERASE_CYCLES = 1200;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] busIn = 8'h00;
  logic       cmdLatch = 1'b0, addrLatch = 1'b0, wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0] busOut;
  logic       readyBusy;
  int         errors = 0;
  int         checks = 0;
  int         cyc = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  nand_cmd_seq #(.PROG_CYCLES(PROG_CYCLES), .ERASE_CYCLES(ERASE_CYCLES)) dut_i (
    .clk(clk), .rstN(rstN), .busIn(busIn), .cmdLatch(cmdLatch),
    .addrLatch(addrLatch), .wrEn(wrEn), .rdEn(rdEn),
    .busOut(busOut), .readyBusy(readyBusy)
  );

  typedef struct packed {
    logic        isErase;
    logic [17:0] row;
    logic [7:0]  col;
    logic [9:0]  len;
    logic [7:0]  dat;
    logic        spareOnly;
    logic        expFail;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 18'h00000, 8'd0,  10'd4,   8'hA5, 1'b0, 1'b0}, // R2 page 0 first main program
    '{1'b0, 18'h00000, 8'd10, 10'd2,   8'h00, 1'b0, 1'b1}, // R9 second main program
    '{1'b0, 18'h00001, 8'd0,  10'd8,   8'hFF, 1'b0, 1'b0}, // R10 ones over stuck cell
    '{1'b1, 18'h0001F, 8'd0,  10'd0,   8'h00, 1'b0, 1'b0}, // R5 page bits set, block 0
    '{1'b0, 18'h00001, 8'd0,  10'd8,   8'h00, 1'b0, 1'b1}, // R10 zero into stuck cell
    '{1'b1, 18'h00003, 8'd0,  10'd0,   8'h00, 1'b0, 1'b0}, // R4 erase block 0 again
    '{1'b0, 18'h00000, 8'd10, 10'd2,   8'h00, 1'b0, 1'b0}, // R5 count cleared by erase
    '{1'b0, 18'h00020, 8'd0,  10'd528, 8'h3C, 1'b1, 1'b0}, // R9 spare 1
    '{1'b0, 18'h00020, 8'd0,  10'd528, 8'h3C, 1'b1, 1'b0}, // R9 spare 2
    '{1'b0, 18'h00020, 8'd0,  10'd528, 8'h3C, 1'b1, 1'b1}  // R9 spare 3 rejected
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrCycle(input logic [7:0] b, input logic c, input logic a);
    busIn = b; cmdLatch = c; addrLatch = a; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; cmdLatch = 1'b0; addrLatch = 1'b0;
  endtask

  task automatic readStat(output logic [7:0] v);
    rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    v = busOut;
  endtask

  task automatic waitReady(input int t0, output int len);
    int guard = 0;
    while (!readyBusy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    len = cyc - t0;
  endtask

  task automatic runVec(input vec_t v, input string req);
    int t0, len;
    logic [7:0] s;
    int expLen;
    if (v.isErase) begin
      wrCycle(8'h60, 1, 0);
      for (int i = 0; i < 3; i++) wrCycle(v.row[8*i +: 8], 0, 1);
      wrCycle(8'hD0, 1, 0);
      expLen = ERASE_CYCLES;
    end else begin
      wrCycle(8'h80, 1, 0);
      wrCycle(v.col, 0, 1);
      for (int i = 0; i < 3; i++) wrCycle(v.row[8*i +: 8], 0, 1);
      for (int i = 0; i < int'(v.len); i++)
        wrCycle((v.spareOnly && (int'(v.col) + i) < 512) ? 8'hFF : v.dat, 0, 0);
      wrCycle(8'h10, 1, 0);
      expLen = PROG_CYCLES;
    end
    t0 = cyc;
    check(readyBusy == 1'b0, req, readyBusy, 0);
    waitReady(t0, len);
    check(len == expLen, req, len, expLen);
    wrCycle(8'h70, 1, 0);
    readStat(s);
    check(s == {1'b0, 1'b1, 5'b0, v.expFail}, req, s, {1'b0, 1'b1, 5'b0, v.expFail});
  endtask

  initial begin
    logic [7:0] s;
    int t0, len;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(readyBusy == 1'b1, "R1", readyBusy, 1);
    check(busOut == 8'h00, "R1", busOut, 0);
    readStat(s);
    check(s == 8'h00, "R8", s, 0);
    wrCycle(8'h70, 1, 0);
    readStat(s);
    check(s == 8'h40, "R1", s, 8'h40);

    // R3 lone confirm, status mode kept (R8)
    wrCycle(8'h10, 1, 0);
    check(readyBusy == 1'b1, "R3", readyBusy, 1);
    readStat(s);
    check(s == 8'h40, "R8", s, 8'h40);
    // R3 confirm after three address cycles
    wrCycle(8'h80, 1, 0);
    for (int i = 0; i < 3; i++) wrCycle(8'h00, 0, 1);
    wrCycle(8'h10, 1, 0);
    check(readyBusy == 1'b1, "R3", readyBusy, 1);
    readStat(s);
    check(s == 8'h00, "R8", s, 0);
    // R4 erase confirm without setup, and with two address cycles
    wrCycle(8'hFF, 1, 0);
    wrCycle(8'hD0, 1, 0);
    check(readyBusy == 1'b1, "R4", readyBusy, 1);
    wrCycle(8'h60, 1, 0);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'hD0, 1, 0);
    check(readyBusy == 1'b1, "R4", readyBusy, 1);
    wrCycle(8'hFF, 1, 0);

    // table of operations
    for (int k = 0; k < NV; k++) begin
      string tag;
      tag = (k == 1 || k >= 7) ? "R9" : (k == 2 || k == 4) ? "R10" :
            (k == 3 || k == 6) ? "R5" : (k == 5) ? "R4" : "R2";
      runVec(VECS[k], tag);
    end

    // R6 commands dropped while busy
    wrCycle(8'h80, 1, 0);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'h21, 0, 1);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'h00, 0, 0);
    wrCycle(8'h10, 1, 0);
    t0 = cyc;
    wrCycle(8'h70, 1, 0);
    readStat(s);
    check(s == 8'h00, "R7", s, 0);
    wrCycle(8'h80, 1, 0);
    readStat(s);
    check(s == 8'h00, "R6", s, 0);
    wrCycle(8'h60, 1, 0);
    wrCycle(8'h10, 1, 0);
    waitReady(t0, len);
    check(len == PROG_CYCLES, "R6", len, PROG_CYCLES);
    readStat(s);
    check(s == 8'h40, "R6", s, 8'h40);
    wrCycle(8'h10, 1, 0);
    check(readyBusy == 1'b1, "R6", readyBusy, 1);
    @(negedge clk);
    check(readyBusy == 1'b1, "R6", readyBusy, 1);

    // R11 abort of a rejected program (page 0 main used again)
    wrCycle(8'h80, 1, 0);
    for (int i = 0; i < 4; i++) wrCycle(8'h00, 0, 1);
    wrCycle(8'h00, 0, 0);
    wrCycle(8'h10, 1, 0);
    wrCycle(8'h70, 1, 0);
    readStat(s);
    check(s == 8'h01, "R9", s, 8'h01);
    repeat (5) @(negedge clk);
    wrCycle(8'hFF, 1, 0);
    check(readyBusy == 1'b1, "R11", readyBusy, 1);
    readStat(s);
    check(s == 8'h00, "R11", s, 0);
    wrCycle(8'h70, 1, 0);
    readStat(s);
    check(s == 8'h40, "R11", s, 8'h40);

    // R11 abort of an erase
    wrCycle(8'h60, 1, 0);
    wrCycle(8'h20, 0, 1);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'h00, 0, 1);
    wrCycle(8'hD0, 1, 0);
    check(readyBusy == 1'b0, "R4", readyBusy, 0);
    repeat (10) @(negedge clk);
    wrCycle(8'hFF, 1, 0);
    check(readyBusy == 1'b1, "R11", readyBusy, 1);

    // R11 pending setup discarded
    wrCycle(8'h80, 1, 0);
    for (int i = 0; i < 4; i++) wrCycle(8'h00, 0, 1);
    wrCycle(8'hFF, 1, 0);
    wrCycle(8'h10, 1, 0);
    check(readyBusy == 1'b1, "R11", readyBusy, 1);
    @(negedge clk);
    check(readyBusy == 1'b1, "R11", readyBusy, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule